// File: doc/BRIEF.md
# Cascadable 8-bit Timer Array

Six independent down-counters share one register-write port and one set of clock-enable strobes. Each counter holds a reload latch. It counts on the enable strobe picked by its source field, and it raises a one-cycle overflow pulse when a count enable arrives while it already reads zero. On that pulse it reloads from its latch, so a latch value n divides its source by n + 1. The overflow pulse also sets a sticky interrupt request flag, which software clears by writing zero to that flag's bit.

Count sources are fixed per timer. They are the shared prescaler strobes (divide by 2, 16 or a slow ratio, taken from the main or the sub clock tick), the raw sub tick, two synchronised external pins, and the overflow pulses of particular neighbours. A timer fed by a neighbour's overflow makes that neighbour its 8-bit prescaler. Every strobe, including a chained overflow, is a one-cycle enable in the single system clock domain.

Top module: `cascade_timer_array`

## Requirements
- R1: After reset every latch and counter holds 0xFF, both mode registers are zero (every timer counts the divide-by-16 strobe from the main tick), and all flags and overflow pulses are 0.
- R2: A write to address i (0..5) loads wr_data into both the latch and the counter of timer i+1 at the next edge. That timer gives no overflow pulse and no count in the write cycle.
- R3: On each selected enable a nonzero counter decrements by one. An enable while the counter is zero gives ovf_o[i]=1 in that cycle and reloads the latch, so latch n yields one overflow per n+1 enables. Without an enable the counter holds.
- R4: The base tick is sub_tick when clk_sel=1 and main_tick otherwise. A free-running prescaler counts base ticks. The divide-by-2, divide-by-16 and slow strobes fire on base ticks where its low 1, 4 or PRE_LOG_HI bits are all ones.
- R5: Timer 1 source, address 6 bits [1:0]: 0 = /16, 1 = slow strobe, 2 or 3 = pin A edge.
- R6: Timer 2 source, address 6 bits [3:2]: 0 = /16, 1 = timer 1 overflow (same cycle), 2 or 3 = pin A edge.
- R7: Timer 3 source, address 6 bits [5:4]: 0 = /16, 1 = raw sub_tick, 2 or 3 = pin B edge. Timer 4 source, address 7 bits [1:0]: 0 = /16, 1 = /2, 2 = raw sub_tick, 3 = timer 3 overflow.
- R8: Timer 5 source, address 7 bits [3:2]: 0 = /16, 1 = timer 2 overflow, 2 or 3 = timer 4 overflow. Timer 6 source, address 7 bit 4: 0 = /16, 1 = timer 5 overflow.
- R9: Each pin passes through two synchronising flops. A rising edge gives one enable, which the counter takes at the third rising clock edge after the pin goes high.
- R10: irq_o[i] is set by ovf_o[i] and stays set. A write to address 8 clears every flag whose wr_data bit is 0. A set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address (0..5 latches, 6 and 7 modes, 8 flag clear) |
| wr_data | input | W | Write data |
| clk_sel | input | 1 | 1 selects the sub tick as the prescaler base |
| main_tick | input | 1 | Main clock enable strobe |
| sub_tick | input | 1 | Sub clock enable strobe |
| ext_a | input | 1 | External count pin shared by timers 1 and 2 |
| ext_b | input | 1 | External count pin of timer 3 |
| ovf_o | output | 6 | Per-timer overflow pulse |
| irq_o | output | 6 | Per-timer interrupt request flag |

## Verification
The bench builds the block with W=8 and PRE_LOG_HI=7, so the slow strobe fires every 128 base ticks instead of 4096. With that setting, timer 1 on the slow source and the chains that feed from it (timer 2, timer 5, timer 6) overflow many times within a short run. It also keeps the default-latch reset case (256 × 16 enables) within reach. The divide-by-2 and divide-by-16 ratios stay at their default values, and random latch values are mostly kept small so that chained overflows, write-versus-overflow collisions and flag set-versus-clear collisions all occur often.

// File: rtl/cascade_timer_array.sv
module cascade_timer_array #(
  parameter int W          = 8,
  parameter int AW         = 4,
  parameter int PRE_LOG_LO = 1,
  parameter int PRE_LOG_MID= 4,
  parameter int PRE_LOG_HI = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          clk_sel,
  input  logic          main_tick,
  input  logic          sub_tick,
  input  logic          ext_a,
  input  logic          ext_b,
  output logic [5:0]    ovf_o,
  output logic [5:0]    irq_o
);
  localparam int NT = 6;
  localparam logic [AW-1:0] A_MODE_A = AW'(6);
  localparam logic [AW-1:0] A_MODE_B = AW'(7);
  localparam logic [AW-1:0] A_IRQ    = AW'(8);

  logic [W-1:0] lat [NT];
  logic [W-1:0] cnt [NT];
  logic [NT-1:0] ld, zr, en_v;
  logic [5:0] mode_a;
  logic [4:0] mode_b;
  logic [PRE_LOG_HI-1:0] pre;
  logic [2:0] sa, sb;
  logic live;

  logic base, p2, p16, pslow, xa, xb;
  logic e1, e2, e3, e4, e5, e6;
  logic o1, o2, o3, o4, o5, o6;

  assign base  = clk_sel ? sub_tick : main_tick;
  assign p2    = base && (&pre[PRE_LOG_LO-1:0]);
  assign p16   = base && (&pre[PRE_LOG_MID-1:0]);
  assign pslow = base && (&pre);
  assign xa    = sa[1] & ~sa[2];
  assign xb    = sb[1] & ~sb[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre  <= '0;
      sa   <= '0;
      sb   <= '0;
      live <= 1'b0;
    end else begin
      if (base) pre <= pre + 1'b1;
      sa   <= {sa[1:0], ext_a};
      sb   <= {sb[1:0], ext_b};
      live <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_a <= '0;
      mode_b <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_MODE_A) mode_a <= wr_data[5:0];
      if (wr_addr == A_MODE_B) mode_b <= wr_data[4:0];
    end
  end

  for (genvar i = 0; i < NT; i++) begin : g_dec
    assign ld[i] = wr_en && (wr_addr == AW'(i));
    assign zr[i] = (cnt[i] == '0);
  end

  assign e1 = (mode_a[1:0] == 2'd0) ? p16 : (mode_a[1:0] == 2'd1) ? pslow : xa;
  assign o1 = e1 & zr[0] & ~ld[0];
  assign e2 = (mode_a[3:2] == 2'd0) ? p16 : (mode_a[3:2] == 2'd1) ? o1 : xa;
  assign o2 = e2 & zr[1] & ~ld[1];
  assign e3 = (mode_a[5:4] == 2'd0) ? p16 : (mode_a[5:4] == 2'd1) ? sub_tick : xb;
  assign o3 = e3 & zr[2] & ~ld[2];

  always_comb begin
    case (mode_b[1:0])
      2'd0:    e4 = p16;
      2'd1:    e4 = p2;
      2'd2:    e4 = sub_tick;
      default: e4 = o3;
    endcase
  end
  assign o4 = e4 & zr[3] & ~ld[3];
  assign e5 = (mode_b[3:2] == 2'd0) ? p16 : (mode_b[3:2] == 2'd1) ? o2 : o4;
  assign o5 = e5 & zr[4] & ~ld[4];
  assign e6 = mode_b[4] ? o5 : p16;
  assign o6 = e6 & zr[5] & ~ld[5];

  assign en_v  = {e6, e5, e4, e3, e2, e1};
  assign ovf_o = {o6, o5, o4, o3, o2, o1};

  for (genvar i = 0; i < NT; i++) begin : g_tmr
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lat[i] <= '1;
        cnt[i] <= '1;
      end else if (ld[i]) begin
        lat[i] <= wr_data;
        cnt[i] <= wr_data;
      end else if (en_v[i]) begin
        cnt[i] <= zr[i] ? lat[i] : cnt[i] - W'(1);
      end
    end

    AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      live && ld[i] |=> (cnt[i] == $past(wr_data)) && (lat[i] == $past(wr_data))); // R2
    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
      live && en_v[i] && !ld[i] && !zr[i] |=> cnt[i] == $past(cnt[i]) - W'(1)); // R3
    AST_OVF_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      live && ovf_o[i] |=> cnt[i] == $past(lat[i])); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      live && !en_v[i] && !ld[i] |=> $stable(cnt[i])); // R3
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      live && ovf_o[i] |=> irq_o[i]); // R10
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      live && irq_o[i] && !(wr_en && wr_addr == A_IRQ && !wr_data[i]) |=> irq_o[i]); // R10
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_o <= '0;
    else if (wr_en && wr_addr == A_IRQ) irq_o <= (irq_o & wr_data[5:0]) | ovf_o;
    else irq_o <= irq_o | ovf_o;
  end

  AST_PRE_NEST_MID: assert property (@(posedge clk) disable iff (!rst_n)
    p16 |-> p2); // R4
  AST_PRE_NEST_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pslow |-> p16); // R4
  AST_PIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    live && xa |=> !xa); // R9
endmodule

// File: tb/sim_cascade_timer_array.sv
module sim_cascade_timer_array;
  localparam int LO = 1, MID = 4, HI = 7;
  localparam logic [HI-1:0] MLO = HI'((1 << LO) - 1);
  localparam logic [HI-1:0] MMID = HI'((1 << MID) - 1);
  localparam logic [HI-1:0] MHI = HI'((1 << HI) - 1);

  logic clk = 0, rst_n = 0, wr_en = 0, clk_sel = 0, main_tick = 0, sub_tick = 0, ext_a = 0, ext_b = 0;
  logic [3:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic [5:0] ovf_o, irq_o;
  int n_cmp = 0, n_bad = 0;
  string tag = "R1";
  int p_main = 100, p_sub = 30, p_wr = 0, p_pin = 0, p_sel = 0;
  int a_lo = 0, a_hi = 5;
  logic [7:0] dmask = 8'hFF;

  always #2.5 clk = ~clk;

  cascade_timer_array #(.W(8), .AW(4), .PRE_LOG_LO(LO), .PRE_LOG_MID(MID), .PRE_LOG_HI(HI)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .clk_sel(clk_sel), .main_tick(main_tick), .sub_tick(sub_tick), .ext_a(ext_a), .ext_b(ext_b),
    .ovf_o(ovf_o), .irq_o(irq_o));

  logic [7:0] mlat [6];
  logic [7:0] mcnt [6];
  logic [5:0] mflag, mma;
  logic [4:0] mmb;
  logic [HI-1:0] mpre;
  logic [2:0] msa, msb;

  function automatic logic [11:0] calc();
    logic base, p2, p16, ps, xa, xb;
    logic [5:0] ld, en, ov;
    base = clk_sel ? sub_tick : main_tick;
    p2 = base && ((mpre & MLO) == MLO);
    p16 = base && ((mpre & MMID) == MMID);
    ps = base && (mpre == MHI);
    xa = msa[1] && !msa[2];
    xb = msb[1] && !msb[2];
    for (int i = 0; i < 6; i++) ld[i] = wr_en && (wr_addr == 4'(i));
    en[0] = (mma[1:0] == 0) ? p16 : (mma[1:0] == 1) ? ps : xa;
    ov[0] = en[0] && mcnt[0] == 0 && !ld[0];
    en[1] = (mma[3:2] == 0) ? p16 : (mma[3:2] == 1) ? ov[0] : xa;
    ov[1] = en[1] && mcnt[1] == 0 && !ld[1];
    en[2] = (mma[5:4] == 0) ? p16 : (mma[5:4] == 1) ? sub_tick : xb;
    ov[2] = en[2] && mcnt[2] == 0 && !ld[2];
    en[3] = (mmb[1:0] == 0) ? p16 : (mmb[1:0] == 1) ? p2 : (mmb[1:0] == 2) ? sub_tick : ov[2];
    ov[3] = en[3] && mcnt[3] == 0 && !ld[3];
    en[4] = (mmb[3:2] == 0) ? p16 : (mmb[3:2] == 1) ? ov[1] : ov[3];
    ov[4] = en[4] && mcnt[4] == 0 && !ld[4];
    en[5] = mmb[4] ? ov[4] : p16;
    ov[5] = en[5] && mcnt[5] == 0 && !ld[5];
    return {en, ov};
  endfunction

  always @(posedge clk) begin : model
    logic [11:0] r;
    if (!rst_n) begin
      for (int i = 0; i < 6; i++) begin mlat[i] <= 8'hFF; mcnt[i] <= 8'hFF; end
      mflag <= 0; mma <= 0; mmb <= 0; mpre <= 0; msa <= 0; msb <= 0;
    end else begin
      r = calc();
      for (int i = 0; i < 6; i++) begin
        if (wr_en && wr_addr == 4'(i)) begin mlat[i] <= wr_data; mcnt[i] <= wr_data; end
        else if (r[6+i]) mcnt[i] <= (mcnt[i] == 0) ? mlat[i] : mcnt[i] - 8'd1;
      end
      if (wr_en && wr_addr == 4'd8) mflag <= (mflag & wr_data[5:0]) | r[5:0];
      else mflag <= mflag | r[5:0];
      if (wr_en && wr_addr == 4'd6) mma <= wr_data[5:0];
      if (wr_en && wr_addr == 4'd7) mmb <= wr_data[4:0];
      if (clk_sel ? sub_tick : main_tick) mpre <= mpre + 1'b1;
      msa <= {msa[1:0], ext_a};
      msb <= {msb[1:0], ext_b};
    end
  end

  task automatic check(string what, logic [5:0] act, logic [5:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at %0t: actual=%h expected=%h", tag, what, $time, act, exp);
    end
  endtask

  task automatic compare();
    logic [11:0] r;
    r = calc();
    check("ovf_o", ovf_o, r[5:0]);
    check("irq_o", irq_o, mflag);
  endtask

  task automatic drive_rand();
    main_tick = ($urandom_range(99) < p_main);
    sub_tick  = ($urandom_range(99) < p_sub);
    if ($urandom_range(99) < p_sel) clk_sel = ~clk_sel;
    if ($urandom_range(99) < p_pin) ext_a = ~ext_a;
    if ($urandom_range(99) < p_pin) ext_b = ~ext_b;
    wr_en = ($urandom_range(99) < p_wr);
    wr_addr = 4'($urandom_range(a_hi, a_lo));
    wr_data = 8'($urandom) & ((wr_addr < 6) ? dmask : 8'hFF);
  endtask

  task automatic step(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      compare();
      drive_rand();
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    compare();
    drive_rand();
    wr_en = 1; wr_addr = a; wr_data = d;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1;
    #1;
    tag = "R1";
    check("reset ovf_o", ovf_o, 6'h00);
    check("reset irq_o", irq_o, 6'h00);
    main_tick = 1;
    step(4200);                       // R1: default latch FF on /16 overflows after 4096 ticks
    tag = "R2"; p_wr = 25; p_main = 100;
    step(2000);
    tag = "R3"; p_wr = 0;
    for (int i = 0; i < 6; i++) wr(4'(i), 8'd0);
    step(300);
    for (int i = 0; i < 6; i++) wr(4'(i), 8'd1);
    step(300);
    p_wr = 3; dmask = 8'h07;
    step(1500);
    tag = "R4"; p_main = 50; p_sub = 30; p_sel = 2; mma = mma;
    wr(4'd7, 8'h01);                   // timer 4 on /2
    step(2500);
    p_sel = 0; clk_sel = 0; p_main = 70;
    tag = "R5"; wr(4'd6, 8'h01); step(2000);
    tag = "R6"; wr(4'd6, 8'h05); step(2000);
    tag = "R7"; wr(4'd6, 8'h10); wr(4'd7, 8'h03); step(2000);
    wr(4'd7, 8'h02); step(1000);
    tag = "R8"; wr(4'd6, 8'h05); wr(4'd7, 8'h14); step(2000);
    wr(4'd7, 8'h1B); step(2000);
    tag = "R9"; p_pin = 20; wr(4'd6, 8'h2A); wr(4'd7, 8'h08); step(3000);
    tag = "R10"; p_pin = 10; dmask = 8'h01; p_wr = 30; a_lo = 0; a_hi = 8;
    for (int i = 0; i < 6; i++) wr(4'(i), 8'd0);
    step(3000);
    tag = "R5-mix"; p_sel = 1; p_sub = 40; dmask = 8'h0F; p_wr = 10;
    step(5000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule